// File: doc/BRIEF.md
# Monitor Identification Sense Sequencer

This block reads the identification code of an attached display through three open-drain ID lines, called A, B and C. After a start strobe it walks through five timed steps. It first drives every line high. It then releases all of them, and then pulls A, B and C low one at a time. At the end of each released or pulled-low step it samples the lines. The samples are packed into a sparse 11-bit code word, and a one-cycle done pulse is raised. The code word is used elsewhere to pick a display mode. That decoding is not part of this block.

The pads take a 6-bit drive word. Bits 5, 4 and 3 release lines A, B and C: 1 means the line floats, 0 means it is driven. Bits 2, 1 and 0 give the level driven onto A, B and C. The sense input returns the pad levels with A on bit 2, B on bit 1 and C on bit 0. Step lengths are counted in delay units. Each unit is `UNIT_CYC` clock cycles. The first step lasts `SHORT_UNITS` units and every later step lasts `LONG_UNITS` units. The defaults are 200 and 2000.

States: `ST_IDLE` (drivers released, waiting), `ST_HIGH` (all driven high), `ST_FLOAT` (all released), `ST_LOW_A`, `ST_LOW_B` and `ST_LOW_C` (one line pulled low). Transitions: `ST_IDLE` goes to `ST_HIGH` on start. Each step moves to the next when its timer runs out, in the order `ST_HIGH`, `ST_FLOAT`, `ST_LOW_A`, `ST_LOW_B`, `ST_LOW_C`. `ST_LOW_C` returns to `ST_IDLE` when its timer runs out, and done is raised on that edge.

Top module: `mon_id_seq`

## Requirements
- R1: After reset the drive word is octal 77 (all released), the code word is zero and done is low.
- R2: A start strobe seen in idle steps the drive word through octal 07, 77, 33, 55, 66 and then returns it to 77, in that order.
- R3: The octal 07 step lasts SHORT_UNITS*UNIT_CYC cycles and each of the four later steps lasts LONG_UNITS*UNIT_CYC cycles. The drive word changes on the clock edge that ends a step.
- R4: At the end of the all-released step, sense bits 2:0 (A, B, C) are stored in code bits 10:8.
- R5: At the end of the A-low step, sense bits 1:0 (B, C) are stored in code bits 5:4.
- R6: At the end of the B-low step, sense bit 2 (A) goes to code bit 3 and sense bit 0 (C) goes to code bit 2.
- R7: At the end of the C-low step, sense bits 2:1 (A, B) are stored in code bits 1:0.
- R8: Code bits 7:6 are always zero.
- R9: Done is high for exactly one cycle. It rises on the edge that ends the C-low step, and in that same cycle the code word is complete and the drive word is octal 77.
- R10: A start strobe given while a sequence runs, including on the edge where done is raised, has no effect on the sequence, its timing or the drive word.
- R11: An accepted start clears the code word to zero on its edge. Between sequences the code word holds its value whatever the sense lines do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, acted on only in idle |
| sense_i | input | 3 | Pad levels of lines A (bit 2), B (bit 1) and C (bit 0) |
| drive_o | output | 6 | Release flags A, B, C on bits 5:3; drive levels A, B, C on bits 2:0 |
| code_o | output | 11 | Assembled identification code |
| done_o | output | 1 | One-cycle pulse when the code is complete |

## Verification
The final sample and a new start strobe can fall on the same edge: the block ends the C-low step just as the strobe arrives. The bench provokes this by holding start high in the cycle before done is due. It then checks three things. The done pulse comes on time, the code matches the finished run, and the drive word stays released with done low one cycle later. A behavioural model of the display supplies the sense levels, with a random set of grounded and bridged ID lines. The expected code is derived from that model.

// File: rtl/mon_id_pkg.sv
package mon_id_pkg;

    localparam int CODE_W = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_FLOAT,
        ST_LOW_A,
        ST_LOW_B,
        ST_LOW_C
    } msense_state_e;

    // drive word: [5:3] release A,B,C ; [2:0] level A,B,C
    localparam logic [5:0] DRV_ALL_HIGH = 6'o07;
    localparam logic [5:0] DRV_RELEASE  = 6'o77;
    localparam logic [5:0] DRV_A_LOW    = 6'o33;
    localparam logic [5:0] DRV_B_LOW    = 6'o55;
    localparam logic [5:0] DRV_C_LOW    = 6'o66;

endpackage

// File: rtl/mon_id_timer.sv
module mon_id_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3: a loaded step length is what the counter holds next cycle
    a_r3_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/mon_id_pack.sv
module mon_id_pack
    import mon_id_pkg::*;
(
    input  msense_state_e     step,
    input  logic              clear,
    input  logic              smp_en,
    input  logic [2:0]        sense,
    input  logic [CODE_W-1:0] code_q,
    output logic [CODE_W-1:0] code_d
);

    always_comb begin
        code_d = code_q;
        if (clear) begin
            code_d = '0;
        end else if (smp_en) begin
            case (step)
                ST_FLOAT: code_d[10:8] = sense;
                ST_LOW_A: code_d[5:4]  = sense[1:0];
                ST_LOW_B: begin
                    code_d[3] = sense[2];
                    code_d[2] = sense[0];
                end
                ST_LOW_C: code_d[1:0]  = sense[2:1];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mon_id_seq.sv
module mon_id_seq
    import mon_id_pkg::*;
#(
    parameter int UNIT_CYC    = 1,
    parameter int SHORT_UNITS = 200,
    parameter int LONG_UNITS  = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        sense_i,
    output logic [5:0]        drive_o,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o
);

    localparam int SHORT_CYC = SHORT_UNITS * UNIT_CYC;
    localparam int LONG_CYC  = LONG_UNITS * UNIT_CYC;
    localparam int MAX_CYC   = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int CW        = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

    msense_state_e     state_q, state_d;
    logic              tmr_load, tmr_zero, smp_en, code_clr;
    logic [CW-1:0]     tmr_val;
    logic [CODE_W-1:0] code_q, code_d;
    logic              done_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)  state_d = ST_HIGH;
            ST_HIGH:  if (tmr_zero) state_d = ST_FLOAT;
            ST_FLOAT: if (tmr_zero) state_d = ST_LOW_A;
            ST_LOW_A: if (tmr_zero) state_d = ST_LOW_B;
            ST_LOW_B: if (tmr_zero) state_d = ST_LOW_C;
            ST_LOW_C: if (tmr_zero) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs and step controls
    always_comb begin
        drive_o  = DRV_RELEASE;
        tmr_load = 1'b0;
        tmr_val  = '0;
        smp_en   = 1'b0;
        code_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                drive_o = DRV_RELEASE;
                if (start_i) begin
                    tmr_load = 1'b1;
                    tmr_val  = SHORT_LD;
                    code_clr = 1'b1;
                end
            end
            ST_HIGH: begin
                drive_o = DRV_ALL_HIGH;
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = LONG_LD;
                end
            end
            ST_FLOAT: begin
                drive_o = DRV_RELEASE;
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = LONG_LD;
                    smp_en   = 1'b1;
                end
            end
            ST_LOW_A: begin
                drive_o = DRV_A_LOW;
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = LONG_LD;
                    smp_en   = 1'b1;
                end
            end
            ST_LOW_B: begin
                drive_o = DRV_B_LOW;
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = LONG_LD;
                    smp_en   = 1'b1;
                end
            end
            ST_LOW_C: begin
                drive_o = DRV_C_LOW;
                if (tmr_zero) begin
                    smp_en = 1'b1;
                end
            end
            default: drive_o = DRV_RELEASE;
        endcase
    end

    mon_id_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    mon_id_pack u_pack (
        .step   (state_q),
        .clear  (code_clr),
        .smp_en (smp_en),
        .sense  (sense_i),
        .code_q (code_q),
        .code_d (code_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            done_q <= 1'b0;
        end else begin
            code_q <= code_d;
            done_q <= (state_q == ST_LOW_C) && tmr_zero;
        end
    end

    assign code_o = code_q;
    assign done_o = done_q;

    // R9: done lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: drivers are released while done is shown
    a_r9_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (drive_o == DRV_RELEASE));

    // R8: unused code bits stay zero
    a_r8_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        code_o[7:6] == 2'b00);

    // R11: accepted start clears the code
    a_r11_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (code_o == '0));

    // R11: idle code is held
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> $stable(code_o));

    // R10: a running step never jumps back to the first step
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_HIGH || $past(state_q) == ST_HIGH));

endmodule

// File: tb/mon_id_seq_test.sv
module mon_id_seq_test;

    localparam int UNIT  = 2;
    localparam int SHORT = 3;
    localparam int LONG  = 5;
    localparam int SC    = SHORT * UNIT;
    localparam int LC    = LONG * UNIT;
    localparam int TOT   = SC + 4 * LC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  sense_i;
    logic [5:0]  drive_o;
    logic [10:0] code_o;
    logic        done_o;

    logic [2:0]  gnd = 3'b000;   // lines grounded by the display: A=2, B=1, C=0
    logic [2:0]  tie = 3'b000;   // bridges: 0 A-B, 1 B-C, 2 A-C

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mon_id_seq #(.UNIT_CYC(UNIT), .SHORT_UNITS(SHORT), .LONG_UNITS(LONG)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sense_i(sense_i),
        .drive_o(drive_o), .code_o(code_o), .done_o(done_o)
    );

    function automatic logic [2:0] lines(input logic [5:0] d, input logic [2:0] g,
                                         input logic [2:0] t);
        logic [2:0] lv;
        for (int i = 0; i < 3; i++)
            lv[i] = !(g[i] || (!d[i+3] && !d[i]));
        for (int p = 0; p < 2; p++) begin
            if (t[0]) begin lv[2] = lv[2] & lv[1]; lv[1] = lv[2]; end
            if (t[1]) begin lv[1] = lv[1] & lv[0]; lv[0] = lv[1]; end
            if (t[2]) begin lv[2] = lv[2] & lv[0]; lv[0] = lv[2]; end
        end
        return lv;
    endfunction

    assign sense_i = lines(drive_o, gnd, tie);

    function automatic logic [10:0] exp_code(input logic [2:0] g, input logic [2:0] t);
        logic [2:0] s1, s2, s3, s4;
        s1 = lines(6'o77, g, t);
        s2 = lines(6'o33, g, t);
        s3 = lines(6'o55, g, t);
        s4 = lines(6'o66, g, t);
        return {s1, 2'b00, s2[1:0], s3[2], s3[0], s4[2:1]};
    endfunction

    function automatic logic [5:0] exp_drive(input int k);
        if (k <= SC) return 6'o07;
        if (k <= SC + LC) return 6'o77;
        if (k <= SC + 2 * LC) return 6'o33;
        if (k <= SC + 3 * LC) return 6'o55;
        if (k <= SC + 4 * LC) return 6'o66;
        return 6'o77;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // busy_at: cycle to pulse start during the run (0 = none); at_done: start on done edge
    task automatic run_seq(input logic [2:0] g, input logic [2:0] t,
                           input int busy_at, input bit at_done);
        int k;
        int bad_k;
        logic [5:0] bad_v;
        logic [10:0] exp;
        gnd = g;
        tie = t;
        exp = exp_code(g, t);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 1;
        check(code_o == 11'd0, "R11 clear", code_o, 0);
        bad_k = 0;
        bad_v = '0;
        while (!done_o && k < TOT + 20) begin
            if (drive_o !== exp_drive(k) && bad_k == 0) begin
                bad_k = k;
                bad_v = drive_o;
            end
            @(negedge clk);
            start_i = 1'b0;
            k++;
            if (busy_at != 0 && k == busy_at) start_i = 1'b1;
            if (at_done && k == TOT) start_i = 1'b1;
        end
        start_i = 1'b0;
        check(bad_k == 0, "R2 R3 drive sequence", bad_v, exp_drive(bad_k));
        check(k == TOT + 1, busy_at != 0 ? "R10 R3 duration" : "R3 duration", k, TOT + 1);
        check(code_o == exp, "R4 R5 R6 R7 code", code_o, exp);
        check(code_o[7:6] == 2'b00, "R8 gap bits", code_o[7:6], 0);
        check(drive_o == 6'o77, "R9 released at done", drive_o, 6'o77);
        @(negedge clk);
        check(done_o == 1'b0, "R9 pulse width", done_o, 0);
        check(drive_o == 6'o77, at_done ? "R10 start at done ignored" : "R9 stays idle",
              drive_o, 6'o77);
        gnd = ~g;
        tie = ~t;
        repeat (3) @(negedge clk);
        check(code_o == exp, "R11 hold", code_o, exp);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        check(drive_o == 6'o77, "R1 drive", drive_o, 6'o77);
        check(code_o == 11'd0, "R1 code", code_o, 0);
        check(done_o == 1'b0, "R1 done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        run_seq(3'b000, 3'b000, 0, 0);   // open monitor: all defined bits set
        run_seq(3'b111, 3'b000, 0, 0);   // all grounded: zero code
        run_seq(3'b000, 3'b111, SC + LC + 2, 0);  // busy start mid-run
        run_seq(3'b010, 3'b001, 0, 1);   // start on the done edge
        run_seq(3'b000, 3'b010, 2, 0);   // busy start in first step
        // random displays
        for (int n = 0; n < 10; n++) begin
            run_seq(3'($urandom), 3'($urandom), (n % 3 == 0) ? int'($urandom_range(2, TOT - 1)) : 0,
                    n % 4 == 1);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule